// File: doc/BRIEF.md
# Dual-Read 64-bit Register File with Zero / Stack-Pointer Alias

This block is the integer register storage of a 64-bit core. It holds thirty-one 64-bit general-purpose registers (indices 0 to 30) and one separate stack pointer. Index 31 has two meanings. A context flag that comes with every access selects which one applies. With the flag low, index 31 is a hard-wired zero: reads give zero and writes are dropped. With the flag high, index 31 is the real stack pointer.

There are two read ports and one general write port. Each carries a 5-bit index, a width select (1 = 64-bit, 0 = 32-bit) and the index-31 context flag. A 32-bit write stores its low half and clears bits 63:32. A 32-bit read returns the low half with the upper half zero. A dedicated link port writes a full 64-bit return address into register 30, so a branch-with-link updates it in the same cycle as the branch.

Read data is registered and appears on the read bus after the clock edge that follows the request. A read that names the entry being written in that cycle returns the newly written value. Reset is synchronous and active high.

Top module: `wide_regfile`

## Requirements
- R1: A 64-bit write to index 0..30 is stored, and a 64-bit read of that index returns it on the read bus one clock edge after the read request. With the write enable low, nothing is stored.
- R2: A read with width select 0 returns bits 31:0 of the selected entry, with bits 63:32 of the read bus at zero.
- R3: A write with width select 0 stores {32'b0, data[31:0]} into its destination, including the stack pointer.
- R4: Index 31 with the context flag at 0 reads as zero, and a write to it changes no entry.
- R5: Index 31 with the context flag at 1 reads and writes the stack pointer. A 32-bit stack-pointer read returns its low half, zero-extended.
- R6: The link port writes its full 64-bit value into register 30 at the clock edge where its enable is high.
- R7: When the link port and the write port both target register 30 in one cycle, the link value is stored. When the write port targets another index, both writes take effect in that cycle.
- R8: A read that names the entry written in the same cycle returns the new value, masked by the read's own width.
- R9: While reset is high at a clock edge, every register, the stack pointer and both read buses become zero.
- R10: The two read ports are independent. Each can read any entry at its own width and context in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A index |
| ra_wide | input | 1 | Read port A width, 1 = 64-bit |
| ra_sp | input | 1 | Read port A index-31 context, 1 = stack pointer, 0 = zero |
| ra_data | output | 64 | Read port A registered data |
| rb_idx | input | 5 | Read port B index |
| rb_wide | input | 1 | Read port B width, 1 = 64-bit |
| rb_sp | input | 1 | Read port B index-31 context |
| rb_data | output | 64 | Read port B registered data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port index |
| wr_wide | input | 1 | Write width, 1 = 64-bit |
| wr_sp | input | 1 | Write index-31 context |
| wr_data | input | 64 | Write data |
| lnk_en | input | 1 | Link-register write enable |
| lnk_data | input | 64 | Return address written into register 30 |

## Verification
A corrupted entry shows up on a read bus one edge after that entry is read. Stale or unmasked data, or a write that lands on the wrong index, is therefore visible within one cycle of the access. A write that wrongly lands on the zero alias shows up as a non-zero value on the first later zero-context read of index 31. A wrong priority on register 30 is exposed by reading that register in the conflict cycle itself, because the read is forwarded. A stack pointer that aliases the zero entry is caught when the same cycle's read on the other port uses the opposite context.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned LINK_IDX = 30;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    logic             wide;
    logic             sp;
  } wr_ctl_t;
endpackage

// File: rtl/wrf_write_merge.sv
module wrf_write_merge #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  parameter int unsigned LINK = 30
) (
  input  wrf_pkg::wr_ctl_t            wctl,
  input  logic [XLEN-1:0]             wdata,
  input  logic                        lnk_en,
  input  logic [XLEN-1:0]             lnk_data,
  output logic [NREG-1:0]             ent_we,
  output logic [NREG-1:0][XLEN-1:0]   ent_wd
);
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned ALIAS = NREG - 1;

  logic [XLEN-1:0] wfmt;
  assign wfmt = wctl.wide ? wdata : {{HALF{1'b0}}, wdata[HALF-1:0]};

  for (genvar e = 0; e < NREG; e++) begin : g_ent
    logic hit;
    if (e == ALIAS) begin : g_alias
      assign hit = wctl.en && (wctl.idx == e[wrf_pkg::IDX_W-1:0]) && wctl.sp;
    end else begin : g_gpr
      assign hit = wctl.en && (wctl.idx == e[wrf_pkg::IDX_W-1:0]);
    end
    if (e == LINK) begin : g_link
      assign ent_we[e] = hit || lnk_en;
      assign ent_wd[e] = lnk_en ? lnk_data : wfmt;
    end else begin : g_plain
      assign ent_we[e] = hit;
      assign ent_wd[e] = wfmt;
    end
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREG-1:0]           ent_we,
  input  logic [NREG-1:0][XLEN-1:0] ent_wd,
  output logic [NREG-1:0][XLEN-1:0] nxt
);
  logic [NREG-1:0][XLEN-1:0] regs;

  for (genvar e = 0; e < NREG; e++) begin : g_cell
    assign nxt[e] = ent_we[e] ? ent_wd[e] : regs[e];
    always_ff @(posedge clk) begin
      if (rst) regs[e] <= '0;
      else     regs[e] <= nxt[e];
    end
  end
endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NREG)-1:0]   idx,
  input  logic                      wide,
  input  logic                      sp,
  input  logic [NREG-1:0][XLEN-1:0] nxt,
  output logic [XLEN-1:0]           q
);
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned ALIAS = NREG - 1;

  logic [XLEN-1:0] raw, fmt;
  logic            zr;

  assign zr  = (idx == ALIAS[$clog2(NREG)-1:0]) && !sp;
  assign raw = zr ? '0 : nxt[idx];
  assign fmt = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= fmt;
  end
endmodule

// File: rtl/wide_regfile.sv
module wide_regfile #(
  parameter int unsigned XLEN = wrf_pkg::WORD_W,
  parameter int unsigned LINK = wrf_pkg::LINK_IDX
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [wrf_pkg::IDX_W-1:0] ra_idx,
  input  logic                      ra_wide,
  input  logic                      ra_sp,
  output logic [XLEN-1:0]           ra_data,
  input  logic [wrf_pkg::IDX_W-1:0] rb_idx,
  input  logic                      rb_wide,
  input  logic                      rb_sp,
  output logic [XLEN-1:0]           rb_data,
  input  logic                      wr_en,
  input  logic [wrf_pkg::IDX_W-1:0] wr_idx,
  input  logic                      wr_wide,
  input  logic                      wr_sp,
  input  logic [XLEN-1:0]           wr_data,
  input  logic                      lnk_en,
  input  logic [XLEN-1:0]           lnk_data
);
  localparam int unsigned NREG  = 2 ** wrf_pkg::IDX_W;
  localparam int unsigned NRD   = 2;

  wrf_pkg::wr_ctl_t                 wctl;
  logic [NREG-1:0]                  ent_we;
  logic [NREG-1:0][XLEN-1:0]        ent_wd;
  logic [NREG-1:0][XLEN-1:0]        nxt;
  logic [NRD-1:0][wrf_pkg::IDX_W-1:0] r_idx;
  logic [NRD-1:0]                   r_wide, r_sp;
  logic [NRD-1:0][XLEN-1:0]         r_q;

  assign wctl = '{en: wr_en, idx: wr_idx, wide: wr_wide, sp: wr_sp};

  wrf_write_merge #(.XLEN(XLEN), .NREG(NREG), .LINK(LINK)) merge_i (
    .wctl(wctl), .wdata(wr_data), .lnk_en(lnk_en), .lnk_data(lnk_data),
    .ent_we(ent_we), .ent_wd(ent_wd)
  );

  wrf_store #(.XLEN(XLEN), .NREG(NREG)) store_i (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_wd(ent_wd), .nxt(nxt)
  );

  assign r_idx  = {rb_idx, ra_idx};
  assign r_wide = {rb_wide, ra_wide};
  assign r_sp   = {rb_sp, ra_sp};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    wrf_read_port #(.XLEN(XLEN), .NREG(NREG)) port_i (
      .clk(clk), .rst(rst), .idx(r_idx[p]), .wide(r_wide[p]), .sp(r_sp[p]),
      .nxt(nxt), .q(r_q[p])
    );
  end

  assign ra_data = r_q[0];
  assign rb_data = r_q[1];
endmodule

// File: rtl/wide_regfile_sva.sv
module wide_regfile_sva #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LINK = 30
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      ra_idx,
  input logic            ra_wide,
  input logic            ra_sp,
  input logic [XLEN-1:0] ra_data,
  input logic [4:0]      rb_idx,
  input logic            rb_wide,
  input logic            rb_sp,
  input logic [XLEN-1:0] rb_data,
  input logic            wr_en,
  input logic [4:0]      wr_idx,
  input logic            wr_wide,
  input logic [XLEN-1:0] wr_data,
  input logic            lnk_en,
  input logic [XLEN-1:0] lnk_data
);
  localparam int unsigned HALF = XLEN / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ra_data == '0) && (rb_data == '0)); // R9

  AST_NARROW_READ_A: assert property (@(posedge clk) disable iff (rst)
    !ra_wide |=> ra_data[XLEN-1:HALF] == '0); // R2

  AST_NARROW_READ_B: assert property (@(posedge clk) disable iff (rst)
    !rb_wide |=> rb_data[XLEN-1:HALF] == '0); // R2

  AST_ZERO_ALIAS_A: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == 5'd31 && !ra_sp) |=> ra_data == '0); // R4

  AST_ZERO_ALIAS_B: assert property (@(posedge clk) disable iff (rst)
    (rb_idx == 5'd31 && !rb_sp) |=> rb_data == '0); // R4

  AST_FWD_WIDE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && ra_wide && wr_idx == ra_idx && ra_idx < 5'd30)
    |=> ra_data == $past(wr_data)); // R8

  AST_NARROW_WRITE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide && ra_wide && wr_idx == ra_idx && ra_idx < 5'd30)
    |=> ra_data == {{HALF{1'b0}}, $past(wr_data[HALF-1:0])}); // R3

  AST_LINK_WINS: assert property (@(posedge clk) disable iff (rst)
    (lnk_en && rb_idx == LINK[4:0] && rb_wide)
    |=> rb_data == $past(lnk_data)); // R7
endmodule

bind wide_regfile wide_regfile_sva #(.XLEN(XLEN), .LINK(LINK)) sva_i (
  .clk(clk), .rst(rst),
  .ra_idx(ra_idx), .ra_wide(ra_wide), .ra_sp(ra_sp), .ra_data(ra_data),
  .rb_idx(rb_idx), .rb_wide(rb_wide), .rb_sp(rb_sp), .rb_data(rb_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide), .wr_data(wr_data),
  .lnk_en(lnk_en), .lnk_data(lnk_data)
);

// File: tb/wide_regfile_tb_top.sv
module wide_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  ra_idx, rb_idx, wr_idx;
  logic        ra_wide, ra_sp, rb_wide, rb_sp, wr_en, wr_wide, wr_sp, lnk_en;
  logic [63:0] ra_data, rb_data, wr_data, lnk_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wide_regfile dut_i (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_wide(ra_wide), .ra_sp(ra_sp), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_wide(rb_wide), .rb_sp(rb_sp), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide), .wr_sp(wr_sp),
    .wr_data(wr_data), .lnk_en(lnk_en), .lnk_data(lnk_data)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  widx;
    logic        wwide;
    logic        wsp;
    logic [63:0] wdat;
    logic        le;
    logic [63:0] ldat;
    logic [4:0]  ai;
    logic        aw;
    logic        asp;
    logic [4:0]  bi;
    logic        bw;
    logic        bsp;
    logic [63:0] ea;
    logic [63:0] eb;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    // R8 R2: wide write x5, forwarded wide on A, narrow on B
    '{1'b1, 5'd5, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0,
      5'd5, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0,
      64'h0123_4567_89AB_CDEF, 64'h0000_0000_89AB_CDEF, 8'd8},
    // R3 R10: narrow write x7 zero-extends; B reads x5 independently
    '{1'b1, 5'd7, 1'b0, 1'b0, 64'hFEDC_BA98_7654_3210, 1'b0, 64'h0,
      5'd7, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0,
      64'h0000_0000_7654_3210, 64'h0123_4567_89AB_CDEF, 8'd3},
    // R4: write to zero alias dropped; stack pointer still zero
    '{1'b1, 5'd31, 1'b1, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0, 64'h0,
      5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1,
      64'h0, 64'h0, 8'd4},
    // R5 R4: stack pointer write; zero alias still reads zero
    '{1'b1, 5'd31, 1'b1, 1'b1, 64'h0000_7FFF_FFFF_FFF0, 1'b0, 64'h0,
      5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b0,
      64'h0000_7FFF_FFFF_FFF0, 64'h0, 8'd5},
    // R5: narrow stack pointer read; x7 retained
    '{1'b0, 5'd0, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0,
      5'd31, 1'b0, 1'b1, 5'd7, 1'b1, 1'b0,
      64'h0000_0000_FFFF_FFF0, 64'h0000_0000_7654_3210, 8'd5},
    // R7: link and write port both on x30, link wins
    '{1'b1, 5'd30, 1'b1, 1'b0, 64'h1111_1111_1111_1111, 1'b1, 64'h0000_0000_0040_1000,
      5'd30, 1'b1, 1'b0, 5'd30, 1'b0, 1'b0,
      64'h0000_0000_0040_1000, 64'h0000_0000_0040_1000, 8'd7},
    // R6 R7: link on x30 while write port hits x3, both land
    '{1'b1, 5'd3, 1'b1, 1'b0, 64'h3333_3333_3333_3333, 1'b1, 64'hFFFF_0000_0040_2000,
      5'd3, 1'b1, 1'b0, 5'd30, 1'b1, 1'b0,
      64'h3333_3333_3333_3333, 64'hFFFF_0000_0040_2000, 8'd6},
    // R1 R2: x0 is an ordinary register
    '{1'b1, 5'd0, 1'b1, 1'b0, 64'h8000_0000_0000_0001, 1'b0, 64'h0,
      5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0,
      64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'd1},
    // R1: write enable low stores nothing
    '{1'b0, 5'd5, 1'b1, 1'b0, 64'hBAD0_BAD0_BAD0_BAD0, 1'b0, 64'h0,
      5'd5, 1'b1, 1'b0, 5'd30, 1'b1, 1'b0,
      64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_0040_2000, 8'd1},
    // R3 R5: narrow stack pointer write zero-extends
    '{1'b1, 5'd31, 1'b0, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 64'h0,
      5'd31, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0,
      64'h0000_0000_CCCC_DDDD, 64'h0000_0000_3333_3333, 8'd3},
    // R1 R4: write port to x30 alone; zero alias narrow
    '{1'b1, 5'd30, 1'b1, 1'b0, 64'h5555_5555_5555_5555, 1'b0, 64'h0,
      5'd30, 1'b1, 1'b0, 5'd31, 1'b0, 1'b0,
      64'h5555_5555_5555_5555, 64'h0, 8'd1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_wide = 1; wr_sp = 0; wr_data = 0;
    lnk_en = 0; lnk_data = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; idle();
    ra_idx = 5; ra_wide = 1; ra_sp = 0; rb_idx = 31; rb_wide = 1; rb_sp = 1;
    @(negedge clk);
    step();
    chk("R9 reset A", ra_data, 64'h0);
    chk("R9 reset B", rb_data, 64'h0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      wr_en = TBL[i].we; wr_idx = TBL[i].widx; wr_wide = TBL[i].wwide;
      wr_sp = TBL[i].wsp; wr_data = TBL[i].wdat;
      lnk_en = TBL[i].le; lnk_data = TBL[i].ldat;
      ra_idx = TBL[i].ai; ra_wide = TBL[i].aw; ra_sp = TBL[i].asp;
      rb_idx = TBL[i].bi; rb_wide = TBL[i].bw; rb_sp = TBL[i].bsp;
      step();
      chk($sformatf("R%0d vec%0d A", TBL[i].rq, i), ra_data, TBL[i].ea);
      chk($sformatf("R%0d vec%0d B", TBL[i].rq, i), rb_data, TBL[i].eb);
    end
    idle();

    // R10: same register on both ports, different widths, no write
    ra_idx = 3; ra_wide = 1; rb_idx = 3; rb_wide = 0;
    step();
    chk("R10 port A wide", ra_data, 64'h3333_3333_3333_3333);
    chk("R10 port B narrow", rb_data, 64'h0000_0000_3333_3333);

    // R9: reset in mid-run clears outputs at once and all storage
    rst = 1; ra_idx = 5; rb_idx = 30; rb_wide = 1;
    step();
    chk("R9 out A during reset", ra_data, 64'h0);
    chk("R9 out B during reset", rb_data, 64'h0);
    rst = 0;
    step();
    chk("R9 x5 cleared", ra_data, 64'h0);
    chk("R9 x30 cleared", rb_data, 64'h0);
    ra_idx = 31; ra_sp = 1; rb_idx = 0;
    step();
    chk("R9 stack pointer cleared", ra_data, 64'h0);
    chk("R9 x0 cleared", rb_data, 64'h0);

    // R6: link alone after reset, read next cycle
    lnk_en = 1; lnk_data = 64'h0000_0000_0040_3000; ra_idx = 1; ra_sp = 0;
    step();
    idle(); rb_idx = 30; rb_wide = 1;
    step();
    chk("R6 link stored", rb_data, 64'h0000_0000_0040_3000);
    chk("R1 x1 untouched by link", ra_data, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule